// File: doc/BRIEF.md
# Minimum-Failed-Check Snapshot Selector

This block sits next to an iterative low-density parity-check decoder. Each time the decoder completes an iteration it presents its hard-decision codeword. The block runs a parity test on that word against a fixed parity-check matrix and counts how many checks fail. It keeps the smallest count seen so far in the current codeword. It also keeps the message bits of the iteration that produced that count. When the decoder signals the end of decoding, the block hands the kept message and its count to an outer decoder. This output replaces the decisions of the final iteration. Error patterns that oscillate or grow over the iterations therefore do not reach the outer stage.

The parity-check matrix is a compile-time parameter of M row masks over N bits. A check fails when the masked codeword has odd parity. A start strobe opens a codeword and a finish strobe closes it. At most MAX_ITER iterations count toward one codeword. An early-stop flag tells the decoder when a word that satisfies every check has been seen, since no later iteration can do better.

Top module: `fcn_snapshot_sel`

## Requirements
- R1: Check r fails when the XOR of iteration bits j with H[r][j]=1 is 1. The failed-check count is the number of failed checks. Default N=12 and M=6, with row masks H[0]=0x00F, H[1]=0x0F0, H[2]=0xF00, H[3]=0x111, H[4]=0x222, H[5]=0x444 (bit j of a mask is variable j).
- R2: A start strobe sets the running minimum to M and discards any stored snapshot. Nothing from an earlier codeword, or from the interrupted part of the current one, affects the next result.
- R3: An accepted iteration whose count is strictly below the running minimum replaces the minimum and stores bits [K-1:0] (default K=6). An equal or larger count changes nothing, so the earliest best iteration is kept.
- R4: A finish strobe while a codeword is open raises done_o for exactly one cycle, in the cycle after the strobe. In that cycle out_bits_o holds the stored message and out_fcn_o holds the minimum count. Both outputs then hold until the next done_o.
- R5: If nothing was stored, finish outputs bits [K-1:0] of the last accepted iteration with count M. If there were no iterations at all, it outputs zero bits with count M.
- R6: Iterations beyond the first MAX_ITER (default 8) of a codeword are ignored.
- R7: An iteration presented in the same cycle as finish is included in the result.
- R8: Iterations and finish strobes outside an open codeword are ignored: done_o stays low and the outputs hold. Start has priority over a finish in the same cycle.
- R9: early_stop_o rises in the cycle after an accepted iteration with zero failed checks. It stays high until finish or start.
- R10: After reset, done_o, early_stop_o, out_bits_o and out_fcn_o are all zero and no codeword is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Opens a new codeword |
| finish_i | input | 1 | Closes the open codeword and requests the result |
| iter_valid_i | input | 1 | An iteration's hard decisions are present |
| iter_bits_i | input | N | Hard-decision codeword of the iteration |
| done_o | output | 1 | One-cycle result strobe |
| out_bits_o | output | K | Selected message bits |
| out_fcn_o | output | $clog2(M+1) | Failed-check count of the selected message |
| early_stop_o | output | 1 | A zero-failure iteration has been seen |

## Verification
The hardest case to reach is the one where no snapshot is ever stored. Every accepted iteration must then fail all M checks at once, and few codewords do. The bench searches the whole 4096-word space with its own parity model for words that fail every check. It feeds several of these in a row, so the fallback to the last iteration can be told apart from a stored snapshot. The iteration limit, the same-cycle finish and ties between equal counts each get directed sequences. Random multi-iteration codewords are checked against a reference model of the running minimum.

// File: rtl/fcn_pkg.sv
package fcn_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/fcn_rst_sync.sv
module fcn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/fcn_syndrome.sv
module fcn_syndrome #(
  parameter int N  = 12,
  parameter int M  = 6,
  parameter int CW = 3,
  parameter logic [M-1:0][N-1:0] H = '0
) (
  input  logic [N-1:0]  bits_i,
  output logic [M-1:0]  synd_o,
  output logic [CW-1:0] count_o
);
  // one parity tree per check row
  for (genvar r = 0; r < M; r++) begin : g_row
    assign synd_o[r] = ^(bits_i & H[r]);
  end

  always_comb begin
    count_o = '0;
    for (int r = 0; r < M; r++) begin
      count_o = count_o + CW'(synd_o[r]);
    end
  end
endmodule

// File: rtl/fcn_ctrl.sv
module fcn_ctrl
  import fcn_pkg::*;
#(
  parameter int MAX_ITER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic finish_i,
  input  logic valid_i,
  output logic accept_o,
  output logic close_o,
  output logic running_o
);
  localparam int IW = $clog2(MAX_ITER + 1);

  run_state_e      state_q, state_d;
  logic [IW-1:0]   iter_q, iter_d;
  logic            state_en, iter_en;

  assign running_o = (state_q == ST_RUN);
  assign accept_o  = running_o && valid_i && !start_i && (iter_q < IW'(MAX_ITER));
  assign close_o   = running_o && finish_i && !start_i;

  always_comb begin
    state_d  = state_q;
    iter_d   = iter_q;
    state_en = 1'b0;
    iter_en  = 1'b0;
    if (start_i) begin
      state_d  = ST_RUN;
      iter_d   = '0;
      state_en = 1'b1;
      iter_en  = 1'b1;
    end else begin
      if (accept_o) begin
        iter_d  = iter_q + 1'b1;
        iter_en = 1'b1;
      end
      if (close_o) begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (iter_en)  iter_q  <= iter_d;
    end
  end
endmodule

// File: rtl/fcn_snap.sv
module fcn_snap #(
  parameter int K  = 6,
  parameter int M  = 6,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          accept_i,
  input  logic          close_i,
  input  logic [CW-1:0] count_i,
  input  logic [K-1:0]  msg_i,
  output logic [CW-1:0] best_cnt_o,
  output logic          done_o,
  output logic [K-1:0]  out_bits_o,
  output logic [CW-1:0] out_fcn_o,
  output logic          early_o
);
  logic [CW-1:0] best_q, best_d;
  logic [K-1:0]  snap_q, snap_d;
  logic [K-1:0]  last_q, last_d;
  logic          have_q, have_d;
  logic          early_q, early_d;
  logic          done_q;
  logic [K-1:0]  obits_q, obits_d;
  logic [CW-1:0] ofcn_q, ofcn_d;
  logic          track_en, out_en, early_en;

  always_comb begin
    best_d   = best_q;
    snap_d   = snap_q;
    last_d   = last_q;
    have_d   = have_q;
    track_en = 1'b0;
    if (clear_i) begin
      best_d   = CW'(M);
      snap_d   = '0;
      last_d   = '0;
      have_d   = 1'b0;
      track_en = 1'b1;
    end else if (accept_i) begin
      last_d   = msg_i;
      track_en = 1'b1;
      if (count_i < best_q) begin
        best_d = count_i;
        snap_d = msg_i;
        have_d = 1'b1;
      end
    end
  end

  // result forwarded from next-state so a same-cycle iteration counts
  always_comb begin
    out_en  = close_i;
    obits_d = have_d ? snap_d : last_d;
    ofcn_d  = best_d;
  end

  always_comb begin
    early_d  = early_q;
    early_en = 1'b0;
    if (clear_i || close_i) begin
      early_d  = 1'b0;
      early_en = 1'b1;
    end else if (accept_i && (count_i == '0)) begin
      early_d  = 1'b1;
      early_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q  <= CW'(M);
      snap_q  <= '0;
      last_q  <= '0;
      have_q  <= 1'b0;
    end else if (track_en) begin
      best_q  <= best_d;
      snap_q  <= snap_d;
      last_q  <= last_d;
      have_q  <= have_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obits_q <= '0;
      ofcn_q  <= '0;
    end else if (out_en) begin
      obits_q <= obits_d;
      ofcn_q  <= ofcn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      done_q <= close_i;
      if (early_en) early_q <= early_d;
    end
  end

  assign best_cnt_o = best_q;
  assign done_o     = done_q;
  assign out_bits_o = obits_q;
  assign out_fcn_o  = ofcn_q;
  assign early_o    = early_q;
endmodule

// File: rtl/fcn_snapshot_sel.sv
module fcn_snapshot_sel #(
  parameter int N        = 12,
  parameter int M        = 6,
  parameter int K        = 6,
  parameter int MAX_ITER = 8,
  parameter logic [M-1:0][N-1:0] H = {12'h444, 12'h222, 12'h111,
                                      12'hF00, 12'h0F0, 12'h00F}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     finish_i,
  input  logic                     iter_valid_i,
  input  logic [N-1:0]             iter_bits_i,
  output logic                     done_o,
  output logic [K-1:0]             out_bits_o,
  output logic [$clog2(M+1)-1:0]   out_fcn_o,
  output logic                     early_stop_o
);
  localparam int CW = $clog2(M + 1);

  logic          rst_sync_n;
  logic [M-1:0]  synd;
  logic [CW-1:0] fcn_count;
  logic [CW-1:0] best_cnt;
  logic          accept, close_cw, running;

  fcn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcn_syndrome #(.N(N), .M(M), .CW(CW), .H(H)) u_synd (
    .bits_i  (iter_bits_i),
    .synd_o  (synd),
    .count_o (fcn_count)
  );

  fcn_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .finish_i  (finish_i),
    .valid_i   (iter_valid_i),
    .accept_o  (accept),
    .close_o   (close_cw),
    .running_o (running)
  );

  fcn_snap #(.K(K), .M(M), .CW(CW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear_i    (start_i),
    .accept_i   (accept),
    .close_i    (close_cw),
    .count_i    (fcn_count),
    .msg_i      (iter_bits_i[K-1:0]),
    .best_cnt_o (best_cnt),
    .done_o     (done_o),
    .out_bits_o (out_bits_o),
    .out_fcn_o  (out_fcn_o),
    .early_o    (early_stop_o)
  );
endmodule

// File: rtl/fcn_snapshot_sel_chk.sv
module fcn_snapshot_sel_chk #(
  parameter int M  = 6,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          finish_i,
  input logic          iter_valid_i,
  input logic          done_o,
  input logic [CW-1:0] out_fcn_o,
  input logic          early_stop_o,
  input logic          running,
  input logic [CW-1:0] best_cnt
);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(finish_i));

  // R5
  fcn_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (out_fcn_o <= CW'(M)));

  // R3
  min_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start_i) |=> (best_cnt <= $past(best_cnt)));

  // R9
  early_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_stop_o) |-> $past(iter_valid_i));

  // R9
  early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !early_stop_o);
endmodule

bind fcn_snapshot_sel fcn_snapshot_sel_chk #(.M(M), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_i      (start_i),
  .finish_i     (finish_i),
  .iter_valid_i (iter_valid_i),
  .done_o       (done_o),
  .out_fcn_o    (out_fcn_o),
  .early_stop_o (early_stop_o),
  .running      (running),
  .best_cnt     (best_cnt)
);

// File: tb/fcn_snapshot_sel_test.sv
`timescale 1ns/1ps
module fcn_snapshot_sel_test;
  localparam int N = 12, M = 6, K = 6, MAXI = 8, CW = 3;
  localparam logic [N-1:0] MASK [M] = '{12'h00F, 12'h0F0, 12'hF00,
                                        12'h111, 12'h222, 12'h444};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, finish_i = 1'b0, iter_valid_i = 1'b0;
  logic [N-1:0] iter_bits_i = '0;
  logic done_o, early_stop_o;
  logic [K-1:0] out_bits_o;
  logic [CW-1:0] out_fcn_o;

  int checks = 0, failures = 0;
  bit ended = 0;
  int m_best, m_iters;
  bit m_have, m_early;
  logic [K-1:0] m_snap, m_last;
  logic [N-1:0] fullfail [$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  fcn_snapshot_sel uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
    .iter_valid_i(iter_valid_i), .iter_bits_i(iter_bits_i),
    .done_o(done_o), .out_bits_o(out_bits_o), .out_fcn_o(out_fcn_o),
    .early_stop_o(early_stop_o));

  function automatic int fails_of(logic [N-1:0] v);
    int n = 0;
    for (int r = 0; r < M; r++) begin
      int par = 0;
      for (int j = 0; j < N; j++) if (MASK[r][j] && v[j]) par ^= 1;
      n += par;
    end
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_accept(logic [N-1:0] v);
    int c = fails_of(v);
    if (m_iters < MAXI) begin
      m_iters++;
      m_last = v[K-1:0];
      if (c < m_best) begin m_best = c; m_snap = v[K-1:0]; m_have = 1; end
      if (c == 0) m_early = 1;
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    m_best = M; m_have = 0; m_early = 0; m_iters = 0; m_snap = '0; m_last = '0;
  endtask

  task automatic do_iter(logic [N-1:0] v);
    @(negedge clk) begin iter_valid_i = 1; iter_bits_i = v; end
    @(negedge clk) iter_valid_i = 0;
    model_accept(v);
    chk(early_stop_o == m_early, "R9 early_stop", early_stop_o, m_early);
  endtask

  task automatic check_result(string req);
    int eb = m_have ? m_snap : m_last;
    chk(done_o == 1, {req, " done"}, done_o, 1);
    chk(out_bits_o == eb, {req, " bits"}, out_bits_o, eb);
    chk(out_fcn_o == m_best, {req, " fcn"}, out_fcn_o, m_best);
    chk(early_stop_o == 0, "R9 early cleared", early_stop_o, 0);
    @(negedge clk);
    chk(done_o == 0, "R4 pulse width", done_o, 0);
  endtask

  task automatic do_finish(string req);
    @(negedge clk) finish_i = 1;
    @(negedge clk) finish_i = 0;
    check_result(req);
  endtask

  function automatic logic [N-1:0] rnd();
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    return lfsr[N-1:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [K-1:0] hold_b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(done_o == 0, "R10 done", done_o, 0);
    chk(early_stop_o == 0, "R10 early", early_stop_o, 0);
    chk(out_bits_o == 0, "R10 bits", out_bits_o, 0);
    chk(out_fcn_o == 0, "R10 fcn", out_fcn_o, 0);

    // R8 idle strobes ignored
    @(negedge clk) begin iter_valid_i = 1; iter_bits_i = 12'h000; finish_i = 1; end
    @(negedge clk) begin iter_valid_i = 0; finish_i = 0; end
    chk(done_o == 0, "R8 idle finish", done_o, 0);
    chk(early_stop_o == 0, "R8 idle iter", early_stop_o, 0);

    // R1 exhaustive single-iteration sweep
    for (int v = 0; v < (1 << N); v++) begin
      if (fails_of(v) == M) fullfail.push_back(N'(v));
      do_start();
      do_iter(N'(v));
      do_finish("R1");
    end

    // R8 after a result, idle iteration leaves outputs alone
    hold_b = out_bits_o;
    @(negedge clk) begin iter_valid_i = 1; iter_bits_i = 12'hFFF; end
    @(negedge clk) iter_valid_i = 0;
    @(negedge clk) finish_i = 1;
    @(negedge clk) finish_i = 0;
    chk(done_o == 0, "R8 no done", done_o, 0);
    chk(out_bits_o == hold_b, "R8 bits hold", out_bits_o, hold_b);

    // R5 no snapshot: several all-failing words, last one wins
    chk(fullfail.size() >= 3, "R5 search", fullfail.size(), 3);
    do_start();
    for (int i = 0; i < 3; i++) do_iter(fullfail[i]);
    do_finish("R5 last word");
    do_start();
    do_finish("R5 empty codeword");

    // R3 tie keeps the earliest
    do_start();
    do_iter(12'h001); do_iter(12'h002); do_iter(12'h421);
    do_finish("R3 tie");
    chk(out_bits_o == 6'h01, "R3 earliest", out_bits_o, 1);

    // R6 iterations beyond the limit are ignored
    do_start();
    for (int i = 0; i < MAXI; i++) do_iter(12'h421);
    do_iter(12'h000);
    chk(early_stop_o == 0, "R6 ignored zero", early_stop_o, 0);
    do_finish("R6 limit");

    // R7 iteration in the same cycle as finish
    do_start();
    do_iter(12'h421);
    @(negedge clk) begin iter_valid_i = 1; iter_bits_i = 12'h000; finish_i = 1; end
    @(negedge clk) begin iter_valid_i = 0; finish_i = 0; end
    model_accept(12'h000);
    m_early = 0;
    check_result("R7 same cycle");

    // R2 restart mid-codeword discards progress
    do_start();
    do_iter(12'h000);
    chk(early_stop_o == 1, "R9 set", early_stop_o, 1);
    do_start();
    chk(early_stop_o == 0, "R2 early cleared", early_stop_o, 0);
    do_iter(12'h421);
    do_finish("R2 restart");

    // R8 start wins over simultaneous finish
    do_start();
    do_iter(12'h001);
    @(negedge clk) begin start_i = 1; finish_i = 1; end
    @(negedge clk) begin start_i = 0; finish_i = 0; end
    chk(done_o == 0, "R8 start priority", done_o, 0);
    m_best = M; m_have = 0; m_early = 0; m_iters = 0; m_snap = '0; m_last = '0;
    do_iter(12'h002);
    do_finish("R8 after restart");

    // R3 R4 R9 random multi-iteration codewords
    for (int s = 0; s < 300; s++) begin
      int len = 1 + (rnd() % (MAXI + 2));
      do_start();
      for (int i = 0; i < len; i++) begin
        logic [N-1:0] w = rnd();
        if (rnd() % 4 == 0) w = w & 12'h0F0;
        do_iter(w);
      end
      do_finish("R3 random");
    end

    ended = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule